// File: doc/BRIEF.md
# Two-Path Level-Priority Interrupt Arbiter

This block sorts up to 64 level-sensitive interrupt lines into two request paths. A per-line class bit sends a pending line either to an active-low fast request output or into the normal path. Each line in the normal path carries a 4-bit software-set level. A registered arbiter picks one normal winner and reports its index and level. A threshold register can veto low levels.

Software reaches the class, level and threshold registers through a plain word-wide port. A write lands on the clock edge where `wrEn` is high. Read data is combinational from `addr` and is valid in the same cycle. The word addresses are: threshold at 0, class words at 2 and 3, and level words at 8 through 15. Any other address reads zero and ignores writes. The arbitration outputs are registered, so they follow a change in the inputs or in a register one clock later.

Top module: `irq_arb_top`

## Requirements
- R1: After reset, all class and level registers read 0 and the threshold reads 31. `nIrq` and `nFiq` are 1, and `winSrc` and `winLvl` are all ones.
- R2: A pending line whose class bit is 1 drives `nFiq` low and never takes part in normal arbitration. The threshold has no effect on `nFiq`.
- R3: A pending line whose class bit is 0 and whose level is not vetoed drives `nIrq` low and can win.
- R4: Among eligible normal lines, the one with the greater level wins.
- R5: Among eligible normal lines that share the greatest level, the one with the greatest index wins.
- R6: A threshold value m in 1..15 vetoes every level less than or equal to m. The values 0 and 16..31 veto nothing. When every pending normal line is vetoed, `nIrq` stays 1.
- R7: When no normal line wins, `nIrq` is 1 and `winSrc` and `winLvl` read all ones.
- R8: The register layout is as follows. The class bit of line n is bit n%32 of word 2+n/32. The level of line n is bits [4*(n%8)+3 : 4*(n%8)] of word 8+n/8. The threshold is bits [4:0] of word 0, and its upper bits read 0. Every mapped word reads back what was written. Unmapped words read 0 and ignore writes.
- R9: `nIrq`, `nFiq`, `winSrc` and `winLvl` change exactly one clock edge after a change on `srcIn`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Register write strobe |
| addr | input | 4 | Word address |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Combinational read data |
| srcIn | input | 64 | Level-sensitive interrupt lines |
| nIrq | output | 1 | Active-low normal request |
| nFiq | output | 1 | Active-low fast request |
| winSrc | output | 6 | Index of the winning normal line |
| winLvl | output | 4 | Level of the winning normal line |

## Verification
The bench builds the block with its default parameters: 64 lines, 4-bit levels and 32-bit words. This gives two class words and eight level words, so the decode covers several words of each kind and both ends of the line range. Lines 0 and 63 sit in the first and last nibble of the level space. At these sizes, the tests cover ties at level 0 and at a mid level, and fast lines that hold the top level. They also cover threshold values on both sides of the 15/16 boundary.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

  localparam int IDX_W = 3;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_MASK = 2'd1,
    SEL_TYPE = 2'd2,
    SEL_PRIO = 2'd3
  } rdSelE;

  typedef struct packed {
    logic             maskWr;
    logic             typeWr;
    logic             prioWr;
    logic [IDX_W-1:0] idx;
    rdSelE            rdSel;
  } ctrlStrobeT;

endpackage

// File: rtl/irq_arb_ctrl.sv
module irq_arb_ctrl
  import irq_arb_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int MASK_ADDR  = 0,
  parameter int TYPE_BASE  = 2,
  parameter int TYPE_WORDS = 2,
  parameter int PRIO_BASE  = 8,
  parameter int PRIO_WORDS = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  output ctrlStrobeT        strobe
);

  logic isMask;
  logic isType;
  logic isPrio;
  int   addrInt;

  always_comb begin
    addrInt = int'(addr);
    isMask  = (addrInt == MASK_ADDR);
    isType  = (addrInt >= TYPE_BASE) && (addrInt < TYPE_BASE + TYPE_WORDS);
    isPrio  = (addrInt >= PRIO_BASE) && (addrInt < PRIO_BASE + PRIO_WORDS);
  end

  always_comb begin
    strobe        = '0;
    strobe.rdSel  = SEL_NONE;
    if (isMask) begin
      strobe.rdSel  = SEL_MASK;
      strobe.maskWr = wrEn;
    end else if (isType) begin
      strobe.rdSel  = SEL_TYPE;
      strobe.typeWr = wrEn;
      strobe.idx    = IDX_W'(addrInt - TYPE_BASE);
    end else if (isPrio) begin
      strobe.rdSel  = SEL_PRIO;
      strobe.prioWr = wrEn;
      strobe.idx    = IDX_W'(addrInt - PRIO_BASE);
    end
  end

  AST_ONE_WRITE_TARGET: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.maskWr, strobe.typeWr, strobe.prioWr})); // R8

  AST_WRITE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |-> !(strobe.maskWr || strobe.typeWr || strobe.prioWr)); // R8

endmodule

// File: rtl/irq_arb_dp.sv
module irq_arb_dp
  import irq_arb_pkg::*;
#(
  parameter int NUM_SRC = 64,
  parameter int LVL_W   = 4,
  parameter int DATA_W  = 32
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  ctrlStrobeT                 strobe,
  input  logic [DATA_W-1:0]          wrData,
  output logic [DATA_W-1:0]          rdData,
  input  logic [NUM_SRC-1:0]         srcIn,
  output logic                       nIrq,
  output logic                       nFiq,
  output logic [$clog2(NUM_SRC)-1:0] winSrc,
  output logic [LVL_W-1:0]           winLvl
);

  localparam int SRC_W      = $clog2(NUM_SRC);
  localparam int MASK_W     = LVL_W + 1;
  localparam int TYPE_WORDS = NUM_SRC / DATA_W;
  localparam int PER_WORD   = DATA_W / LVL_W;
  localparam int PRIO_WORDS = NUM_SRC / PER_WORD;

  logic [NUM_SRC-1:0]             typeReg;
  logic [PRIO_WORDS-1:0][DATA_W-1:0] prioReg;
  logic [MASK_W-1:0]              maskReg;
  logic [NUM_SRC-1:0][LVL_W-1:0]  srcLvl;

  function automatic logic lvlBlocked(input logic [LVL_W-1:0] lvl,
                                      input logic [MASK_W-1:0] thr);
    return (thr != '0) && !thr[MASK_W-1] && ({1'b0, lvl} <= thr);
  endfunction

  // threshold register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              maskReg <= '1;
    else if (strobe.maskWr) maskReg <= wrData[MASK_W-1:0];
  end

  // class words
  for (genvar w = 0; w < TYPE_WORDS; w++) begin : gTypeWord
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        typeReg[w*DATA_W +: DATA_W] <= '0;
      else if (strobe.typeWr && (int'(strobe.idx) == w))
        typeReg[w*DATA_W +: DATA_W] <= wrData;
    end
  end

  // level words
  for (genvar w = 0; w < PRIO_WORDS; w++) begin : gPrioWord
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        prioReg[w] <= '0;
      else if (strobe.prioWr && (int'(strobe.idx) == w))
        prioReg[w] <= wrData;
    end
  end

  // per-line level extraction
  for (genvar n = 0; n < NUM_SRC; n++) begin : gLvl
    assign srcLvl[n] = prioReg[n / PER_WORD][(n % PER_WORD)*LVL_W +: LVL_W];
  end

  // read mux
  always_comb begin
    rdData = '0;
    unique case (strobe.rdSel)
      SEL_MASK: rdData = DATA_W'(maskReg);
      SEL_TYPE: rdData = typeReg[int'(strobe.idx)*DATA_W +: DATA_W];
      SEL_PRIO: rdData = prioReg[int'(strobe.idx) % PRIO_WORDS];
      default:  rdData = '0;
    endcase
  end

  // arbitration: ascending scan with >= keeps the greatest index on a tie
  logic             anyFast;
  logic             found;
  logic [SRC_W-1:0] bestSrc;
  logic [LVL_W-1:0] bestLvl;

  always_comb begin
    anyFast = |(srcIn & typeReg);
    found   = 1'b0;
    bestSrc = '1;
    bestLvl = '1;
    for (int n = 0; n < NUM_SRC; n++) begin
      if (srcIn[n] && !typeReg[n] && !lvlBlocked(srcLvl[n], maskReg)) begin
        if (!found || (srcLvl[n] >= bestLvl)) begin
          found   = 1'b1;
          bestSrc = SRC_W'(n);
          bestLvl = srcLvl[n];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      nIrq   <= 1'b1;
      nFiq   <= 1'b1;
      winSrc <= '1;
      winLvl <= '1;
    end else begin
      nIrq   <= !found;
      nFiq   <= !anyFast;
      winSrc <= bestSrc;
      winLvl <= bestLvl;
    end
  end

  // assertion support: history of the inputs
  logic               pastValid;
  logic [NUM_SRC-1:0] srcPrev;
  logic [NUM_SRC-1:0] typePrev;
  logic [MASK_W-1:0]  maskPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pastValid <= 1'b0;
      srcPrev   <= '0;
      typePrev  <= '0;
      maskPrev  <= '1;
    end else begin
      pastValid <= 1'b1;
      srcPrev   <= srcIn;
      typePrev  <= typeReg;
      maskPrev  <= maskReg;
    end
  end

  AST_IDLE_ALL_ONES: assert property (@(posedge clk) disable iff (!rstN)
    nIrq |-> (winSrc == '1) && (winLvl == '1)); // R7

  AST_WINNER_PENDING: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && !nIrq) |-> (srcPrev[winSrc] && !typePrev[winSrc])); // R3

  AST_WINNER_NOT_VETOED: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && !nIrq) |-> !lvlBlocked(winLvl, maskPrev)); // R6

  AST_FAST_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    pastValid |-> (nFiq == ((srcPrev & typePrev) == '0))); // R2

endmodule

// File: rtl/irq_arb_top.sv
module irq_arb_top
  import irq_arb_pkg::*;
#(
  parameter int NUM_SRC = 64,
  parameter int LVL_W   = 4,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 4
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       wrEn,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [DATA_W-1:0]          wrData,
  output logic [DATA_W-1:0]          rdData,
  input  logic [NUM_SRC-1:0]         srcIn,
  output logic                       nIrq,
  output logic                       nFiq,
  output logic [$clog2(NUM_SRC)-1:0] winSrc,
  output logic [LVL_W-1:0]           winLvl
);

  localparam int TYPE_WORDS = NUM_SRC / DATA_W;
  localparam int PRIO_WORDS = NUM_SRC / (DATA_W / LVL_W);

  ctrlStrobeT strobe;

  irq_arb_ctrl #(
    .ADDR_W    (ADDR_W),
    .MASK_ADDR (0),
    .TYPE_BASE (2),
    .TYPE_WORDS(TYPE_WORDS),
    .PRIO_BASE (8),
    .PRIO_WORDS(PRIO_WORDS)
  ) i_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .wrEn  (wrEn),
    .addr  (addr),
    .strobe(strobe)
  );

  irq_arb_dp #(
    .NUM_SRC(NUM_SRC),
    .LVL_W  (LVL_W),
    .DATA_W (DATA_W)
  ) i_dp (
    .clk   (clk),
    .rstN  (rstN),
    .strobe(strobe),
    .wrData(wrData),
    .rdData(rdData),
    .srcIn (srcIn),
    .nIrq  (nIrq),
    .nFiq  (nFiq),
    .winSrc(winSrc),
    .winLvl(winLvl)
  );

endmodule

// File: tb/test_irq_arb_top.sv
`timescale 1ns/1ps
module test_irq_arb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic [63:0] srcIn = '0;
  logic        nIrq;
  logic        nFiq;
  logic [5:0]  winSrc;
  logic [3:0]  winLvl;

  int tests = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  irq_arb_top i_irq_arb_top (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .srcIn(srcIn), .nIrq(nIrq), .nFiq(nFiq),
    .winSrc(winSrc), .winLvl(winLvl)
  );

  typedef struct packed {
    logic [63:0] src;
    logic        eIrq;
    logic        eFiq;
    logic [5:0]  eSrc;
    logic [3:0]  eLvl;
  } vecT;

  // setup: lvl(3)=7, lvl(10)=7, lvl(20)=2, lvl(40)=15, lvl(63)=1; lines 5 and 40 fast
  localparam vecT VEC [10] = '{
    '{64'h0,                               1'b1, 1'b1, 6'd63, 4'd15}, // R7
    '{64'h8,                               1'b0, 1'b1, 6'd3,  4'd7 }, // R3
    '{64'h408,                             1'b0, 1'b1, 6'd10, 4'd7 }, // R5
    '{64'h8000_0000_0010_0000,             1'b0, 1'b1, 6'd20, 4'd2 }, // R4
    '{64'h20,                              1'b1, 1'b0, 6'd63, 4'd15}, // R2
    '{64'h0000_0100_0000_0001,             1'b0, 1'b0, 6'd0,  4'd0 }, // R2
    '{64'h7,                               1'b0, 1'b1, 6'd2,  4'd0 }, // R5
    '{64'h8000_0000_0000_0001,             1'b0, 1'b1, 6'd63, 4'd1 }, // R4
    '{64'h0000_0000_0010_0028,             1'b0, 1'b0, 6'd3,  4'd7 }, // R4
    '{64'hFFFF_FFFF_FFFF_FFFF,             1'b0, 1'b0, 6'd10, 4'd7 }  // R5
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input string req, input logic [3:0] a, input logic [31:0] exp);
    @(negedge clk);
    addr = a;
    #0.5;
    chk(req, 64'(rdData), 64'(exp));
  endtask

  task automatic apply(input logic [63:0] s);
    @(negedge clk);
    srcIn = s;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic outs(input string req, input logic eI, input logic eF,
                      input logic [5:0] eS, input logic [3:0] eL);
    chk({req, " nIrq"},   64'(nIrq),   64'(eI));
    chk({req, " nFiq"},   64'(nFiq),   64'(eF));
    chk({req, " winSrc"}, 64'(winSrc), 64'(eS));
    chk({req, " winLvl"}, 64'(winLvl), 64'(eL));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    outs("R1", 1'b1, 1'b1, 6'h3F, 4'hF);
    rd("R1 mask", 4'd0, 32'd31);
    rd("R1 type0", 4'd2, 32'h0);
    rd("R1 type1", 4'd3, 32'h0);
    for (int w = 8; w < 16; w++) rd("R1 prio", 4'(w), 32'h0);

    // R8 layout and read-back
    wr(4'd8,  32'h0000_7000);   // line 3 -> 7
    wr(4'd9,  32'h0000_0700);   // line 10 -> 7
    wr(4'd10, 32'h0002_0000);   // line 20 -> 2
    wr(4'd13, 32'h0000_000F);   // line 40 -> 15
    wr(4'd15, 32'h1000_0000);   // line 63 -> 1
    wr(4'd2,  32'h0000_0020);   // line 5 fast
    wr(4'd3,  32'h0000_0100);   // line 40 fast
    wr(4'd1,  32'hDEAD_BEEF);   // unmapped
    rd("R8 prio word 8",  4'd8,  32'h0000_7000);
    rd("R8 prio word 15", 4'd15, 32'h1000_0000);
    rd("R8 type word 3",  4'd3,  32'h0000_0100);
    rd("R8 unmapped",     4'd1,  32'h0);
    rd("R8 mask kept",    4'd0,  32'd31);

    // vector table
    for (int i = 0; i < 10; i++) begin
      apply(VEC[i].src);
      outs($sformatf("R2-5 vec%0d", i), VEC[i].eIrq, VEC[i].eFiq, VEC[i].eSrc, VEC[i].eLvl);
    end

    // R6 threshold veto
    wr(4'd0, 32'hFFFF_FFE7);    // only low 5 bits kept -> 7
    rd("R8 mask width", 4'd0, 32'd7);
    apply(64'h8000_0000_0010_0008);
    outs("R6 thr7 all vetoed", 1'b1, 1'b1, 6'h3F, 4'hF);
    wr(4'd0, 32'd6);
    apply(64'h8000_0000_0010_0008);
    outs("R6 thr6", 1'b0, 1'b1, 6'd3, 4'd7);
    wr(4'd0, 32'd0);
    apply(64'h1);
    outs("R6 thr0", 1'b0, 1'b1, 6'd0, 4'd0);
    wr(4'd0, 32'd16);
    apply(64'h1);
    outs("R6 thr16", 1'b0, 1'b1, 6'd0, 4'd0);
    wr(4'd0, 32'd15);
    apply(64'h0000_0100_0000_0021);
    outs("R6 thr15 fast unaffected R2", 1'b1, 1'b0, 6'h3F, 4'hF);
    wr(4'd0, 32'd31);

    // R9 one-clock latency
    apply(64'h0);
    @(negedge clk);
    srcIn = 64'h8;
    #0.5;
    chk("R9 before edge", 64'(nIrq), 64'd1);
    @(posedge clk);
    #0.5;
    chk("R9 after edge nIrq", 64'(nIrq), 64'd0);
    chk("R9 after edge winSrc", 64'(winSrc), 64'd3);

    // R1 reset again clears registers
    @(negedge clk);
    rstN = 1'b0;
    #0.5;
    outs("R1 re-reset", 1'b1, 1'b1, 6'h3F, 4'hF);
    @(negedge clk);
    rstN = 1'b1;
    rd("R1 re-reset prio", 4'd8, 32'h0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule